// File: doc/BRIEF.md
# Graphics engine interrupt controller

This block collects the interrupt sources of a tile-binning graphics engine and presents them to software as one interrupt line. Three sources feed it. Two are single-cycle events: the binner has flushed its last tile list, and the renderer has finished a frame. The third is a level condition: the binner has run out of overflow memory and stalls until new memory is handed to it. Events are latched into a pending register. Software acknowledges a pending bit by writing 1 to it. The out-of-memory bit cannot be acknowledged while the shortage lasts.

Software chooses which pending bits may raise the interrupt through an enable mask. The mask is never written directly. One register sets mask bits and another clears them, and reading either register returns the mask. Two more registers hold the base and size of the overflow memory pool given to the binner. A nonzero write to the size register ends the shortage. After that, the out-of-memory bit can be acknowledged.

The bus is a simple word-addressed register port. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, the pending register, the enable mask, the pool base and the pool size all read zero, and `irq_o` is low.
- R2: Register offsets are: 0 = pending, 1 = enable-set, 2 = enable-clear, 3 = pool base, 4 = pool size. Any other offset reads zero. Source bits in the pending register and the mask are: bit 0 = out of memory, bit 1 = flush done, bit 2 = frame done. All other bits read zero.
- R3: Writing 1 to a flush-done or frame-done pending bit clears it. Pending bits written as 0 are left unchanged.
- R4: When an event arrives in the same cycle as a write-1 acknowledge of its own bit, the event wins and the bit stays set.
- R5: A write to enable-set turns on every mask bit written as 1. Mask bits written as 0 keep their value.
- R6: A write to enable-clear turns off every mask bit written as 1. Mask bits written as 0 keep their value.
- R7: Reading enable-set or enable-clear returns the current mask.
- R8: A pulse on `oom_req_i` starts a shortage. The out-of-memory pending bit then becomes set, and stays set through write-1 acknowledges for as long as the shortage lasts.
- R9: A write of a nonzero value to pool size ends the shortage from the next cycle onward. A write of zero does not end it. Once the shortage has ended, a write-1 acknowledge clears the out-of-memory bit.
- R10: `irq_o` is high exactly when, on the previous clock edge, some pending bit had its mask bit set. This gives one cycle of latency from the registers to the pin.
- R11: The pool base and pool size registers read back the last value written. They also drive `pool_base_o` and `pool_size_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (3) | Word offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| oom_req_i | input | 1 | Binner reports it has run out of overflow memory |
| flush_done_i | input | 1 | Binner last-flush event, one cycle |
| frame_done_i | input | 1 | Renderer frame-complete event, one cycle |
| pool_base_o | output | DATA_W (32) | Overflow pool base handed to the binner |
| pool_size_o | output | DATA_W (32) | Overflow pool size handed to the binner |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume two things about the inputs. The event inputs are sampled on the clock like any other synchronous signal. A write and a source event may coincide in the same cycle. The shortage property also assumes that the binner does not raise `oom_req_i` again in the cycle where the size register is written.

The stimulus respects these assumptions. It drives all inputs on the falling edge and holds each event high for exactly one cycle. It deliberately overlaps an event with its own acknowledge. It raises the shortage request only while no size write is in progress.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int SRC_N      = 3;
  localparam int SRC_OOM    = 0;
  localparam int SRC_FLUSH  = 1;
  localparam int SRC_FRAME  = 2;

  localparam int OFF_PEND   = 0;
  localparam int OFF_EN_SET = 1;
  localparam int OFF_EN_CLR = 2;
  localparam int OFF_PBASE  = 3;
  localparam int OFF_PSIZE  = 4;
endpackage

// File: rtl/gfx_irq_rst_sync.sv
module gfx_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gfx_irq_pend.sv
module gfx_irq_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_comb pend_d[b] = set_i[b] | (pend_q[b] & ~ack_i[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gfx_irq_mask.sv
module gfx_irq_mask #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q, mask_d;
  logic         mask_en;

  always_comb begin
    mask_d = mask_q;
    if (set_we) mask_d = mask_q | bits_i;
    if (clr_we) mask_d = mask_q & ~bits_i;
  end

  assign mask_en = set_we | clr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              size_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oom_req_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] size_o,
  output logic              starved_o
);
  logic [DATA_W-1:0] base_q, size_q;
  logic              starved_q, starved_d;
  logic              supply;

  assign supply = size_we & (wdata != '0);

  always_comb starved_d = oom_req_i | (starved_q & ~supply);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_q <= '0;
    else if (size_we) size_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) starved_q <= 1'b0;
    else        starved_q <= starved_d;
  end

  assign base_o    = base_q;
  assign size_o    = size_q;
  assign starved_o = starved_q;
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              oom_req_i,
  input  logic              flush_done_i,
  input  logic              frame_done_i,
  output logic [DATA_W-1:0] pool_base_o,
  output logic [DATA_W-1:0] pool_size_o,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic              we_pend, we_set, we_clr, we_base, we_size;
  logic [SRC_N-1:0]  src_set, pend_ack, pend_q, mask_q;
  logic              starved;
  logic              irq_q, irq_d;

  gfx_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    we_pend = bus_we && (bus_addr == ADDR_W'(OFF_PEND));
    we_set  = bus_we && (bus_addr == ADDR_W'(OFF_EN_SET));
    we_clr  = bus_we && (bus_addr == ADDR_W'(OFF_EN_CLR));
    we_base = bus_we && (bus_addr == ADDR_W'(OFF_PBASE));
    we_size = bus_we && (bus_addr == ADDR_W'(OFF_PSIZE));
  end

  gfx_irq_pool #(.DATA_W(DATA_W)) u_pool (
    .clk(clk), .rst_n(rst_sync_n),
    .base_we(we_base), .size_we(we_size), .wdata(bus_wdata),
    .oom_req_i(oom_req_i),
    .base_o(pool_base_o), .size_o(pool_size_o), .starved_o(starved)
  );

  always_comb begin
    src_set            = '0;
    src_set[SRC_OOM]   = starved;
    src_set[SRC_FLUSH] = flush_done_i;
    src_set[SRC_FRAME] = frame_done_i;
    pend_ack           = we_pend ? bus_wdata[SRC_N-1:0] : '0;
  end

  gfx_irq_pend #(.N(SRC_N)) u_pend (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(src_set), .ack_i(pend_ack), .pend_o(pend_q)
  );

  gfx_irq_mask #(.N(SRC_N)) u_mask (
    .clk(clk), .rst_n(rst_sync_n),
    .set_we(we_set), .clr_we(we_clr),
    .bits_i(bus_wdata[SRC_N-1:0]), .mask_o(mask_q)
  );

  always_comb irq_d = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_PEND):   bus_rdata = DATA_W'(pend_q);
      ADDR_W'(OFF_EN_SET),
      ADDR_W'(OFF_EN_CLR): bus_rdata = DATA_W'(mask_q);
      ADDR_W'(OFF_PBASE):  bus_rdata = pool_base_o;
      ADDR_W'(OFF_PSIZE):  bus_rdata = pool_size_o;
      default:             bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk
  import gfx_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              oom_req_i,
  input logic              flush_done_i,
  input logic [SRC_N-1:0]  pend,
  input logic [SRC_N-1:0]  mask,
  input logic              starved,
  input logic              irq_o
);
  // R10
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pend & mask)));

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done_i |=> pend[SRC_FLUSH]);

  // R8
  oom_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    starved |=> pend[SRC_OOM]);

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_EN_SET)) |=>
      ((mask & $past(bus_wdata[SRC_N-1:0])) == $past(bus_wdata[SRC_N-1:0])));

  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_EN_CLR)) |=>
      ((mask & $past(bus_wdata[SRC_N-1:0])) == '0));

  // R9
  supply_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_PSIZE) && bus_wdata != '0 && !oom_req_i)
      |=> !starved);
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .oom_req_i(oom_req_i), .flush_done_i(flush_done_i),
  .pend(pend_q), .mask(mask_q), .starved(starved), .irq_o(irq_o)
);

// File: tb/gfx_irq_ctrl_tb_top.sv
module gfx_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic        oom_req_i, flush_done_i, frame_done_i;
  logic [31:0] pool_base_o, pool_size_o;
  logic        irq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gfx_irq_ctrl dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); check("R1 pending", v, 0);
    rd(1, v); check("R1 mask", v, 0);
    rd(3, v); check("R1 base", v, 0);
    rd(4, v); check("R1 size", v, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    rd(7, v); check("R2 unused offset", v, 0);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    @(negedge clk); flush_done_i = 1'b1;
    @(negedge clk); flush_done_i = 1'b0;
    rd(0, v); check("R2 flush bit1", v, 32'h2);
    wr(0, 32'h0); rd(0, v); check("R3 zero write keeps", v, 32'h2);
    wr(0, 32'h2); rd(0, v); check("R3 ack flush", v, 0);
    @(negedge clk); frame_done_i = 1'b1;
    @(negedge clk); frame_done_i = 1'b0;
    rd(0, v); check("R2 frame bit2", v, 32'h4);
    wr(0, 32'h4); rd(0, v); check("R3 ack frame", v, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk); flush_done_i = 1'b1; bus_addr = 0; bus_we = 1'b1; bus_wdata = 32'h2;
    @(negedge clk); flush_done_i = 1'b0; bus_we = 1'b0;
    rd(0, v); check("R4 event wins", v, 32'h2);
    wr(0, 32'h2); rd(0, v); check("R4 later ack", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(1, 32'h5); rd(1, v); check("R5 set", v, 32'h5);
    rd(2, v); check("R7 read via clear", v, 32'h5);
    wr(1, 32'h0); rd(1, v); check("R5 zero set keeps", v, 32'h5);
    wr(2, 32'h1); rd(2, v); check("R6 clear", v, 32'h4);
    wr(2, 32'h0); rd(1, v); check("R6 zero clear keeps", v, 32'h4);
  endtask

  task automatic t_irq;
    @(negedge clk); frame_done_i = 1'b1;
    @(negedge clk); frame_done_i = 1'b0;
    check("R10 not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R10 raised", {31'b0, irq_o}, 1);
    @(negedge clk); bus_addr = 0; bus_we = 1'b1; bus_wdata = 32'h4;
    @(negedge clk); bus_we = 1'b0;
    check("R10 held one cycle", {31'b0, irq_o}, 1);
    @(negedge clk);
    check("R10 dropped", {31'b0, irq_o}, 0);
    @(negedge clk); flush_done_i = 1'b1;
    @(negedge clk); flush_done_i = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 masked source", {31'b0, irq_o}, 0);
    wr(0, 32'h2);
  endtask

  task automatic t_oom;
    logic [31:0] v;
    @(negedge clk); oom_req_i = 1'b1;
    @(negedge clk); oom_req_i = 1'b0;
    @(negedge clk);
    rd(0, v); check("R8 oom set", v, 32'h1);
    wr(0, 32'h1); rd(0, v); check("R8 sticky", v, 32'h1);
    wr(4, 32'h0); wr(0, 32'h1); rd(0, v); check("R9 zero size no supply", v, 32'h1);
    wr(3, 32'h0001_2000); rd(3, v); check("R11 base", v, 32'h0001_2000);
    check("R11 base pin", pool_base_o, 32'h0001_2000);
    wr(4, 32'h0004_0000); rd(4, v); check("R11 size", v, 32'h0004_0000);
    check("R11 size pin", pool_size_o, 32'h0004_0000);
    wr(0, 32'h1); rd(0, v); check("R9 ack after supply", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    oom_req_i = 1'b0; flush_done_i = 1'b0; frame_done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ack();
    t_collide();
    t_mask();
    t_irq();
    t_oom();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule